// File: doc/BRIEF.md
# Scan Chain Access Sequencer

This block holds a parameterised chain of state flip-flops that front a piece of combinational logic supplied from outside. Each flip-flop takes its D input through a two-way selector. One side is the next-state value computed by the logic. The other side is the bit one step earlier in the chain. A single test-mode control drives every selector. With test mode low a clock captures the functional next state. With test mode high the flip-flops form a shift register that runs from the serial input toward the serial output.

A built-in sequencer drives the chain through fixed-length procedures, so a tester or a higher-level controller never has to count clocks. It can:
- force an arbitrary present state, and recover the previous one as it leaves;
- take one functional step;
- capture a next state and read it out, either overwriting the chain from the serial input pin or rotating it so that the captured state survives.

Between commands the chain holds its value.

Commands arrive on a valid/ready handshake. A command is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` is low for the whole duration of an operation, so a caller must hold `cmd_valid` until it sees ready. A request raised while busy is simply not taken and leaves no trace. The parallel result offers no back-pressure. It is qualified by a one-cycle `done` pulse and stays stable until the next accepted command starts to refill it.

Top module: `scan_chain_seq`

## Requirements
- R1: After synchronous active-high reset, `present_state` is all zeros, `busy` and `done` are 0, `cmd_ready` is 1 and `result` is all zeros.
- R2: A command is accepted only on an edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is 0 whenever `busy` is 1. A command presented while busy has no effect on the chain, the result or the length of the running operation, and starts nothing afterwards.
- R3: While idle and no command is accepted, the chain holds its value and `test_mode` is 0.
- R4: Op code 0 (load) runs exactly N shift clocks and leaves `present_state` equal to `load_vec`. Bit N-1 of `load_vec` enters the chain first.
- R5: During a load the previous state leaves on `scan_out`. Afterwards `result` bit i equals chain bit i as it was before the load.
- R6: Op code 1 (step) applies one functional clock: `present_state` becomes the `next_state` seen in the busy cycle, and `busy` lasts exactly one cycle.
- R7: In each cycle with `test_mode` high, chain bit i+1 takes bit i, bit 0 takes the serial input, and `scan_out` always shows chain bit N-1.
- R8: Op code 2 (destructive unload) captures one next state and then shifts N-1 times, feeding the `scan_in` pin into bit 0. Busy lasts N cycles. `result` equals the captured state. The chain ends with captured bit 0 in position N-1 and the `scan_in` values below it.
- R9: In the cycle right after the capture clock of an unload, before any shift, `scan_out` already shows captured bit N-1.
- R10: Op code 3 (preserving unload) captures one next state and then rotates the chain N times, with `scan_out` fed back into bit 0. Busy lasts N+1 cycles. Both `result` and `present_state` end equal to the captured state.
- R11: `done` is a one-cycle pulse in the first cycle after the final clock of an operation, with `busy` already 0.
- R12: `test_mode` is high only in shift cycles of an operation, never while idle and never in a capture cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command can be accepted (sequencer idle) |
| cmd_op | input | 2 | Operation: 0 load, 1 step, 2 unload, 3 preserving unload |
| load_vec | input | CHAIN_LEN | Target state for a load, sampled at acceptance |
| next_state | input | CHAIN_LEN | Next state from the functional logic |
| present_state | output | CHAIN_LEN | Chain contents, driven to the functional logic |
| scan_in | input | 1 | Serial input used by the destructive unload |
| scan_out | output | 1 | Serial output, last chain bit |
| test_mode | output | 1 | Shift-mode indication for the chain selectors |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| result | output | CHAIN_LEN | Bits collected from the serial output |

## Verification
Counted from the accepting edge, the chain and result are final after N clocks for a load and for a destructive unload, after N+1 clocks for a preserving unload, and after 1 clock for a step. The first captured bit appears on `scan_out` one clock after acceptance. The bench drives on falling edges and, after each acceptance, counts the falling edges at which `busy` is high. It compares that count with these figures, samples `scan_out` at the second busy sample, and reads `done`, `result` and `present_state` at the first sample where `busy` has dropped.

// File: rtl/scan_chain_pkg.sv
package scan_chain_pkg;
  typedef enum logic [1:0] {
    OP_LOAD      = 2'd0,
    OP_STEP      = 2'd1,
    OP_DUMP      = 2'd2,
    OP_DUMP_KEEP = 2'd3
  } scan_op_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_CAPT  = 2'd1,
    PH_SHIFT = 2'd2
  } phase_e;
endpackage

// File: rtl/scan_cell.sv
module scan_cell (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tm,
  input  logic d_func,
  input  logic d_scan,
  output logic q
);
  logic d_sel;

  // two-way selector in front of the flip-flop
  always_comb d_sel = tm ? d_scan : d_func;

  always_ff @(posedge clk) begin
    if (rst)     q <= 1'b0;
    else if (en) q <= d_sel;
  end
endmodule

// File: rtl/scan_chain_ctrl.sv
module scan_chain_ctrl
  import scan_chain_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cmd_valid,
  input  logic [1:0]   cmd_op,
  input  logic [N-1:0] load_vec,
  input  logic         scan_in,
  input  logic         scan_out,
  output logic         cmd_ready,
  output logic         busy,
  output logic         done,
  output logic         chain_en,
  output logic         test_mode,
  output logic         chain_si,
  output logic         collect,
  output logic         collect_tail
);
  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] LAST_FULL  = CW'(N - 1);
  localparam logic [CW-1:0] LAST_SHORT = CW'(N - 2);

  phase_e         phase;
  scan_op_e       op_r;
  logic [CW-1:0]  cnt;
  logic [N-1:0]   vec_r;
  logic           accept;

  assign busy      = (phase != PH_IDLE);
  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;
  assign chain_en  = busy;
  assign test_mode = (phase == PH_SHIFT);
  assign collect   = (phase == PH_SHIFT);
  assign collect_tail = (phase == PH_SHIFT) && (cnt == '0) && (op_r == OP_DUMP);

  // serial source for chain bit 0
  always_comb begin
    unique case (op_r)
      OP_LOAD:      chain_si = vec_r[N-1];
      OP_DUMP_KEEP: chain_si = scan_out;
      default:      chain_si = scan_in;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      op_r  <= OP_LOAD;
      cnt   <= '0;
      vec_r <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (accept) begin
            op_r  <= scan_op_e'(cmd_op);
            vec_r <= load_vec;
            if (scan_op_e'(cmd_op) == OP_LOAD) begin
              phase <= PH_SHIFT;
              cnt   <= LAST_FULL;
            end else begin
              phase <= PH_CAPT;
            end
          end
        end
        PH_CAPT: begin
          unique case (op_r)
            OP_DUMP: begin
              phase <= PH_SHIFT;
              cnt   <= LAST_SHORT;
            end
            OP_DUMP_KEEP: begin
              phase <= PH_SHIFT;
              cnt   <= LAST_FULL;
            end
            default: begin
              phase <= PH_IDLE;
              done  <= 1'b1;
            end
          endcase
        end
        PH_SHIFT: begin
          vec_r <= {vec_r[N-2:0], 1'b0};
          if (cnt == '0) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scan_chain_collect.sv
module scan_chain_collect #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         collect,
  input  logic         tail,
  input  logic         so,
  input  logic         tap,
  output logic [N-1:0] result
);
  logic [N:0]   one_bit;
  logic [N+1:0] two_bit;

  assign one_bit = {result, so};
  assign two_bit = {result, so, tap};

  always_ff @(posedge clk) begin
    if (rst)          result <= '0;
    else if (collect) result <= tail ? two_bit[N-1:0] : one_bit[N-1:0];
  end
endmodule

// File: rtl/scan_chain_seq.sv
module scan_chain_seq #(
  parameter int CHAIN_LEN = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [1:0]           cmd_op,
  input  logic [CHAIN_LEN-1:0] load_vec,
  input  logic [CHAIN_LEN-1:0] next_state,
  output logic [CHAIN_LEN-1:0] present_state,
  input  logic                 scan_in,
  output logic                 scan_out,
  output logic                 test_mode,
  output logic                 busy,
  output logic                 done,
  output logic [CHAIN_LEN-1:0] result
);
  localparam int TAP = (CHAIN_LEN >= 2) ? CHAIN_LEN - 2 : 0;

  logic chain_en, chain_si, collect, collect_tail;
  logic [CHAIN_LEN-1:0] q;

  assign present_state = q;
  assign scan_out      = q[CHAIN_LEN-1];

  scan_chain_ctrl #(.N(CHAIN_LEN)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .load_vec     (load_vec),
    .scan_in      (scan_in),
    .scan_out     (scan_out),
    .cmd_ready    (cmd_ready),
    .busy         (busy),
    .done         (done),
    .chain_en     (chain_en),
    .test_mode    (test_mode),
    .chain_si     (chain_si),
    .collect      (collect),
    .collect_tail (collect_tail)
  );

  for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
    logic d_scan;
    if (i == 0) begin : g_head
      assign d_scan = chain_si;
    end else begin : g_link
      assign d_scan = q[i-1];
    end
    scan_cell u_cell (
      .clk    (clk),
      .rst    (rst),
      .en     (chain_en),
      .tm     (test_mode),
      .d_func (next_state[i]),
      .d_scan (d_scan),
      .q      (q[i])
    );
  end

  scan_chain_collect #(.N(CHAIN_LEN)) u_collect (
    .clk     (clk),
    .rst     (rst),
    .collect (collect),
    .tail    (collect_tail),
    .so      (scan_out),
    .tap     (q[TAP]),
    .result  (result)
  );
endmodule

// File: rtl/scan_chain_seq_chk.sv
module scan_chain_seq_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         cmd_valid,
  input logic         cmd_ready,
  input logic [N-1:0] next_state,
  input logic [N-1:0] present_state,
  input logic         scan_out,
  input logic         test_mode,
  input logic         busy,
  input logic         done
);
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(cmd_valid && cmd_ready)) |=> $stable(present_state));

  // R7
  shift_step_chk: assert property (@(posedge clk) disable iff (rst)
    test_mode |=> (present_state[N-1:1] == $past(present_state[N-2:0])));

  // R6
  capture_load_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !test_mode) |=> (present_state == $past(next_state)));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  done_on_finish_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R12
  mode_busy_chk: assert property (@(posedge clk) disable iff (rst)
    test_mode |-> busy);

  // R2
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !cmd_ready);
endmodule

bind scan_chain_seq scan_chain_seq_chk #(.N(CHAIN_LEN)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cmd_valid     (cmd_valid),
  .cmd_ready     (cmd_ready),
  .next_state    (next_state),
  .present_state (present_state),
  .scan_out      (scan_out),
  .test_mode     (test_mode),
  .busy          (busy),
  .done          (done)
);

// File: tb/tb_scan_chain_seq.sv
module tb_scan_chain_seq;
  localparam int CL = 4;
  localparam int NS = 1 << CL;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [CL-1:0] load_vec = '0;
  logic [CL-1:0] next_state;
  logic scan_in = 1'b0;
  logic cmd_ready, scan_out, test_mode, busy, done;
  logic [CL-1:0] present_state, result;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  // functional logic stand-in: next = 3*present + 1 modulo 2^CL
  function automatic logic [CL-1:0] fn(input logic [CL-1:0] s);
    int t;
    t = int'(s) * 3 + 1;
    return t[CL-1:0];
  endfunction

  always_comb next_state = fn(present_state);

  scan_chain_seq #(.CHAIN_LEN(CL)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .load_vec(load_vec), .next_state(next_state),
    .present_state(present_state), .scan_in(scan_in), .scan_out(scan_out),
    .test_mode(test_mode), .busy(busy), .done(done), .result(result)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // issue one command and follow it to completion; ncyc counts busy samples
  task automatic run_op(input logic [1:0] op, input logic [CL-1:0] vec,
                        input bit poke, output int ncyc, output logic so_first,
                        output logic tm_first, output int ready_err);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; load_vec = vec;
    @(negedge clk);
    cmd_valid = 1'b0;
    ncyc = 0; so_first = 1'b0; tm_first = 1'b0; ready_err = 0;
    while (busy && ncyc < 100) begin
      if (ncyc == 0) tm_first = test_mode;
      if (ncyc == 1) so_first = scan_out;
      if (cmd_ready) ready_err++;
      if (poke && ncyc == 1) begin
        cmd_valid = 1'b1; cmd_op = 2'd1; load_vec = ~vec;
      end else begin
        cmd_valid = 1'b0;
      end
      ncyc++;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int n;
    logic sf, tf;
    int re;
    logic [CL-1:0] prev, cap, exp_chain;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 state", present_state, 0);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 ready", cmd_ready, 1);
    check("R1 result", result, 0);
    check("R3 idle test_mode", test_mode, 0);

    // R4 / R5: load every target, previous state comes back in result
    prev = '0;
    for (int v = 0; v < NS; v++) begin
      run_op(2'd0, CL'(v), 1'b0, n, sf, tf, re);
      check("R4 load cycles", n, CL);
      check("R4 load state", present_state, v);
      check("R5 old state out", result, prev);
      check("R11 done", done, 1);
      check("R2 ready low while busy", re, 0);
      @(negedge clk);
      check("R11 done one cycle", done, 0);
      prev = CL'(v);
    end

    // R3: holding while idle
    repeat (5) @(negedge clk);
    check("R3 hold", present_state, NS - 1);

    // R6: single functional step from every state
    for (int v = 0; v < NS; v++) begin
      run_op(2'd0, CL'(v), 1'b0, n, sf, tf, re);
      run_op(2'd1, '0, 1'b0, n, sf, tf, re);
      check("R6 step cycles", n, 1);
      check("R6 step state", present_state, fn(CL'(v)));
      check("R12 no shift in step", tf, 0);
    end

    // R10 / R9: preserving unload
    for (int v = 0; v < NS; v++) begin
      run_op(2'd0, CL'(v), 1'b0, n, sf, tf, re);
      cap = fn(CL'(v));
      run_op(2'd3, '0, 1'b0, n, sf, tf, re);
      check("R10 keep cycles", n, CL + 1);
      check("R10 keep result", result, cap);
      check("R10 keep state", present_state, cap);
      check("R9 first bit", sf, cap[CL-1]);
      check("R12 capture cycle not shift", tf, 0);
    end

    // R8 / R7: destructive unload with serial input at 0 and at 1
    for (int s = 0; s < 2; s++) begin
      scan_in = s[0];
      for (int v = 0; v < NS; v++) begin
        run_op(2'd0, CL'(v), 1'b0, n, sf, tf, re);
        cap = fn(CL'(v));
        run_op(2'd2, '0, 1'b0, n, sf, tf, re);
        exp_chain = s[0] ? CL'((1 << (CL - 1)) - 1) : '0;
        exp_chain[CL-1] = cap[0];
        check("R8 dump cycles", n, CL);
        check("R8 dump result", result, cap);
        check("R7 R8 dump chain", present_state, exp_chain);
        check("R9 first bit", sf, cap[CL-1]);
      end
    end
    scan_in = 1'b0;

    // R2: a request during a load is dropped
    run_op(2'd0, 4'b0101, 1'b0, n, sf, tf, re);
    run_op(2'd0, 4'b1010, 1'b1, n, sf, tf, re);
    check("R2 busy length kept", n, CL);
    check("R2 state unaffected", present_state, 4'b1010);
    check("R2 result unaffected", result, 4'b0101);
    repeat (3) begin
      @(negedge clk);
      check("R2 nothing started", busy, 0);
    end
    check("R2 state after", present_state, 4'b1010);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule